// File: doc/BRIEF.md
# SPI Serial EEPROM Write Engine

This block is the device end of a serial EEPROM, seen only through the instructions that change it. It takes chip select, serial clock and serial input, and it oversamples them with the system clock. It decodes five instructions: set write enable, clear write enable, read status, write status and write data. It keeps a small status register and fills a 128-byte page buffer as data bytes arrive. It answers status reads on the serial output. At all other times that output is high impedance. The bus may idle low (SPI mode 0) or high (mode 3). In both modes, input bits are taken on the rising clock edge and output bits change on the falling edge.

A write is committed only when chip select is released. The commit goes to the main byte array, or to a separate 128-byte identification page when the status register selects it. The commit happens at the end of a busy period of `WRITE_CYCLES` system clocks. Only bytes that were actually loaded are written. A debug read port exposes both arrays so the stored contents can be observed.

Opcodes: `0x06` set enable, `0x04` clear enable, `0x05` read status, `0x01` write status, `0x02` write data. Status byte layout, MSB first: `{0, 0, lock, idsel, prot[1], prot[0], wel, busy}`.

Top module: `spi_eeprom_wr`

## Requirements
- R1: After reset the status byte reads `0x00`, and every byte of both arrays reads `0xFF` on the debug port.
- R2: Opcode `0x06` followed by chip-select release sets wel (status bit 1), and opcode `0x04` clears it. Opcode `0x05` returns the status byte on `so`, MSB first, starting with the falling edge after the opcode. This works in both mode 0 and mode 3.
- R3: A write-data instruction is ignored when wel is 0: no busy period starts and the array is unchanged.
- R4: Opcode `0x02`, then a 16-bit address (high byte first), then N whole data bytes stores byte k at page offset (addr+k) mod 128. The write lands only when the busy period ends, `WRITE_CYCLES` clocks after chip select rises. Until then the old contents read back, and bytes that were not loaded keep their value.
- R5: Status bit 0 reads 1 during the busy period. When the period ends, bit 0 returns to 0 and wel is cleared.
- R6: Loading past offset 127 wraps to offset 0 of the same page, and later bytes overwrite earlier ones.
- R7: While busy, every instruction except read status has no effect. For example, `0x04` does not clear wel.
- R8: If chip select rises with a partial data byte, or with no data byte, nothing is written and no busy period starts.
- R9: Opcode `0x01` followed by one byte, with wel set, loads prot from byte bits 3:2, idsel from bit 4 and lock from bit 5, and clears wel. Without wel it is ignored. Lock can be set but never cleared.
- R10: With idsel = 1, a write goes to the identification page at offset A6:A0, and A15:A7 do not select the byte. Idsel is cleared when the write completes.
- R11: An identification-page write is rejected when lock = 1, when prot = 11, or when the address falls inside the protected range.
- R12: The protected range is selected by prot, over the top address bits of the array: 01 protects the upper quarter, 10 the upper half and 11 everything. A write whose address falls in the range is rejected; a write outside it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| peek_id | input | 1 | Debug read selects identification page |
| peek_addr | input | ADDR_W | Debug read address (bits 6:0 for the identification page) |
| so | output | 1 | Serial data out, high impedance unless returning status |
| peek_data | output | 8 | Debug read data |

## Verification
Suppose the enable latch or the selection bits hold a wrong value. The next status read shows it within one 16-bit transaction, and the target array then shows a missing or misplaced byte once the busy period has elapsed. A page-offset counter that fails to wrap, or a commit that fires too early, shows as wrong bytes at specific debug addresses. Those bytes are read both just after chip select rises and after the busy time. A protection or lock decode that is wrong shows a byte that should have stayed `0xFF`, or a busy bit that is set when it should be clear.

// File: rtl/spi_eeprom_wr.sv
module spi_eeprom_wr #(
  parameter int ADDR_W       = 10,
  parameter int WRITE_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              peek_id,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic              so,
  output logic [7:0]        peek_data
);
  localparam int MEM_BYTES = 1 << ADDR_W;
  localparam int PG_W      = ADDR_W - 7;
  localparam int CNT_W     = $clog2(WRITE_CYCLES + 1);
  localparam logic [7:0] OP_WRSR = 8'h01, OP_WRITE = 8'h02, OP_WRDI = 8'h04,
                         OP_RDSR = 8'h05, OP_WREN = 8'h06;

  logic [2:0] cs_q, sck_q;
  logic [1:0] si_q;
  logic [6:0] sh;
  logic [2:0] bcnt;
  logic [1:0] nbyte;
  logic       have_data;
  logic [7:0] opcode, out_sh;
  logic [ADDR_W-1:0] addr;
  logic [3:0] wrsr_val;
  logic       so_q, busy, wel, ipl, lip, tgt_id;
  logic [1:0] bp;
  logic [CNT_W-1:0] cnt;
  logic [PG_W-1:0]  page;
  logic [7:0] pbuf [128];
  logic [127:0] vld;
  logic [7:0] mem [MEM_BYTES];
  logic [7:0] idm [128];

  wire cs_lo     = !cs_q[1];
  wire cs_rise   = cs_q[1] & !cs_q[2];
  wire cs_fall   = !cs_q[1] & cs_q[2];
  wire sck_rise  = cs_lo & sck_q[1] & !sck_q[2];
  wire sck_fall  = cs_lo & !sck_q[1] & sck_q[2];
  wire [7:0] byte_in = {sh, si_q[1]};
  wire byte_done = sck_rise && bcnt == 3'd7;
  wire [7:0] status = {2'b00, lip, ipl, bp, wel, busy};
  wire prot = (bp == 2'd3) || (bp == 2'd2 && addr[ADDR_W-1]) ||
              (bp == 2'd1 && &addr[ADDR_W-1:ADDR_W-2]);
  wire clean = (bcnt == 3'd0) && !busy;
  wire wr_ok = clean && wel && opcode == OP_WRITE && have_data && !prot && !(ipl && lip);
  wire commit = busy && cnt == CNT_W'(1);

  assign so = (cs_lo && opcode == OP_RDSR) ? so_q : 1'bz;
  assign peek_data = peek_id ? idm[peek_addr[6:0]] : mem[peek_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 3'b111; sck_q <= 3'b000; si_q <= 2'b00;
      sh <= '0; bcnt <= '0; nbyte <= '0; have_data <= 1'b0;
      opcode <= '0; out_sh <= '0; addr <= '0; wrsr_val <= '0; so_q <= 1'b0;
      busy <= 1'b0; wel <= 1'b0; ipl <= 1'b0; lip <= 1'b0; bp <= '0;
      tgt_id <= 1'b0; cnt <= '0; page <= '0; vld <= '0;
      for (int i = 0; i < 128; i++) pbuf[i] <= 8'h00;
    end else begin
      cs_q  <= {cs_q[1:0], cs_n};
      sck_q <= {sck_q[1:0], sck};
      si_q  <= {si_q[0], si};
      if (cs_fall) begin
        bcnt <= '0; nbyte <= '0; opcode <= '0; have_data <= 1'b0;
      end
      if (sck_rise) begin
        sh   <= byte_in[6:0];
        bcnt <= bcnt + 3'd1;
      end
      if (byte_done) begin
        if (nbyte != 2'd3) nbyte <= nbyte + 2'd1;
        case (nbyte)
          2'd0: begin
            opcode <= byte_in;
            if (byte_in == OP_WRITE && !busy) vld <= '0;
            if (byte_in == OP_RDSR) out_sh <= status;
          end
          2'd1: begin
            addr[ADDR_W-1:8] <= byte_in[ADDR_W-9:0];
            if (opcode == OP_WRSR) wrsr_val <= byte_in[5:2];
          end
          2'd2: addr[7:0] <= byte_in;
          default: ;
        endcase
        if (opcode == OP_RDSR) out_sh <= status;
        if (nbyte == 2'd3 && opcode == OP_WRITE && !busy) begin
          pbuf[addr[6:0]] <= byte_in;
          vld[addr[6:0]]  <= 1'b1;
          addr[6:0]       <= addr[6:0] + 7'd1;
          have_data       <= 1'b1;
        end
      end
      if (sck_fall && opcode == OP_RDSR) begin
        so_q   <= out_sh[7];
        out_sh <= {out_sh[6:0], 1'b0};
      end
      if (cs_rise && clean) begin
        case (opcode)
          OP_WREN: wel <= 1'b1;
          OP_WRDI: wel <= 1'b0;
          OP_WRSR: if (wel && nbyte >= 2'd2) begin
            bp  <= wrsr_val[1:0];
            ipl <= wrsr_val[2];
            lip <= lip | wrsr_val[3];
            wel <= 1'b0;
          end
          default: ;
        endcase
      end
      if (cs_rise && wr_ok) begin
        busy   <= 1'b1;
        cnt    <= CNT_W'(WRITE_CYCLES);
        tgt_id <= ipl;
        page   <= addr[ADDR_W-1:7];
      end
      if (busy) begin
        cnt <= cnt - CNT_W'(1);
        if (commit) begin
          busy <= 1'b0; wel <= 1'b0; ipl <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < 128; i++) idm[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < 128; i++)
        if (vld[i]) begin
          if (tgt_id) idm[7'(i)] <= pbuf[7'(i)];
          else        mem[{page, 7'(i)}] <= pbuf[7'(i)];
        end
    end
  end
endmodule

// File: rtl/spi_eeprom_wr_chk.sv
module spi_eeprom_wr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       wel,
  input logic       ipl,
  input logic       lip,
  input logic [1:0] bp,
  input logic       cs_rise
);
  a_r5_busy_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> wel);
  a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!wel && !ipl));
  a_r7_status_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(bp) && $stable(lip) && $stable(ipl)));
  a_r4_start_on_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise));
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lip) |-> lip);
endmodule

bind spi_eeprom_wr spi_eeprom_wr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wel(wel), .ipl(ipl),
  .lip(lip), .bp(bp), .cs_rise(cs_rise)
);

// File: tb/tb_spi_eeprom_wr.sv
`timescale 1ns/1ps
module tb_spi_eeprom_wr;
  localparam int AW = 10;
  localparam int WC = 1000;
  localparam time HALF = 40ns;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic peek_id = 1'b0;
  logic [AW-1:0] peek_addr = '0;
  wire so;
  wire [7:0] peek_data;
  int nchk = 0, nerr = 0;
  logic [7:0] tx [0:139];
  logic [7:0] rx [0:139];

  spi_eeprom_wr #(.ADDR_W(AW), .WRITE_CYCLES(WC)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .peek_id(peek_id), .peek_addr(peek_addr), .so(so), .peek_data(peek_data));

  always #4ns clk = ~clk;

  // mode, address, data
  localparam logic [24:0] VEC [6] = '{
    {1'b0, 16'h0010, 8'h11}, {1'b1, 16'h007F, 8'h22}, {1'b0, 16'h00A3, 8'h33},
    {1'b1, 16'h0155, 8'h44}, {1'b0, 16'h02FE, 8'h55}, {1'b1, 16'h03FF, 8'h66}};

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input int nbits, input bit m3);
    sck = m3; #HALF;
    cs_n = 1'b0; #HALF;
    for (int b = 0; b < nbits; b++) begin
      if (m3) sck = 1'b0;
      si = tx[b/8][7 - b%8];
      #HALF;
      rx[b/8][7 - b%8] = so;
      sck = 1'b1;
      #HALF;
      if (!m3) sck = 1'b0;
    end
    #HALF;
    cs_n = 1'b1;
    #(2*HALF);
  endtask

  task automatic op(input logic [7:0] code, input bit m3 = 0);
    tx[0] = code; xfer(8, m3);
  endtask

  task automatic rdsr(output logic [7:0] v, input bit m3 = 0);
    tx[0] = 8'h05; tx[1] = 8'h00; xfer(16, m3); v = rx[1];
  endtask

  task automatic wrsr(input logic [7:0] v);
    tx[0] = 8'h01; tx[1] = v; xfer(16, 0);
  endtask

  task automatic wr(input logic [15:0] a, input int n, input bit m3 = 0, input int nbits = -1);
    tx[0] = 8'h02; tx[1] = a[15:8]; tx[2] = a[7:0];
    xfer(nbits < 0 ? 24 + 8*n : nbits, m3);
  endtask

  task automatic wait_done();
    repeat (WC + 40) @(posedge clk);
  endtask

  task automatic peek(input bit id, input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk); peek_id = id; peek_addr = a; #1ns; v = peek_data;
  endtask

  initial begin
    logic [7:0] v;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);

    rdsr(v);            chk("R1 status", v, 8'h00);
    peek(0, 10'h000, v); chk("R1 array", v, 8'hFF);
    peek(1, 10'h000, v); chk("R1 id page", v, 8'hFF);

    foreach (VEC[k]) begin
      op(8'h06, VEC[k][24]);
      tx[3] = VEC[k][7:0];
      wr(VEC[k][23:8], 1, VEC[k][24]);
      wait_done();
      peek(0, VEC[k][17:8], v); chk("R4 table", v, VEC[k][7:0]);
    end

    op(8'h06, 1); rdsr(v, 1); chk("R2 wel set mode3", v, 8'h02);
    op(8'h04);    rdsr(v, 0); chk("R2 wel clear mode0", v, 8'h00);

    tx[3] = 8'h77; wr(16'h0040, 1);
    rdsr(v); chk("R3 no busy", v, 8'h00);
    wait_done();
    peek(0, 10'h040, v); chk("R3 array kept", v, 8'hFF);

    op(8'h06);
    tx[3] = 8'hA1; tx[4] = 8'hA2; tx[5] = 8'hA3; wr(16'h0105, 3);
    peek(0, 10'h105, v); chk("R4 not yet", v, 8'hFF);
    rdsr(v); chk("R5 busy", v, 8'h03);
    op(8'h04);
    rdsr(v); chk("R7 ignored while busy", v, 8'h03);
    wait_done();
    rdsr(v); chk("R5 done clears wel", v, 8'h00);
    peek(0, 10'h105, v); chk("R4 byte0", v, 8'hA1);
    peek(0, 10'h106, v); chk("R4 byte1", v, 8'hA2);
    peek(0, 10'h107, v); chk("R4 byte2", v, 8'hA3);

    op(8'h06);
    tx[3] = 8'hB0; tx[4] = 8'hB1; tx[5] = 8'hB2; tx[6] = 8'hB3; wr(16'h017E, 4);
    wait_done();
    peek(0, 10'h17E, v); chk("R6 pre-wrap", v, 8'hB0);
    peek(0, 10'h17F, v); chk("R6 end of page", v, 8'hB1);
    peek(0, 10'h100, v); chk("R6 wrapped0", v, 8'hB2);
    peek(0, 10'h101, v); chk("R6 wrapped1", v, 8'hB3);
    peek(0, 10'h105, v); chk("R4 unloaded kept", v, 8'hA1);

    op(8'h06);
    for (int i = 0; i < 129; i++) tx[3+i] = 8'(i + 1);
    wr(16'h0200, 129);
    wait_done();
    peek(0, 10'h200, v); chk("R6 overwrite", v, 8'h81);
    peek(0, 10'h201, v); chk("R6 second", v, 8'h02);
    peek(0, 10'h27F, v); chk("R6 last", v, 8'h80);

    op(8'h06);
    tx[3] = 8'h99; wr(16'h0300, 1, 0, 28);
    rdsr(v); chk("R8 partial no busy", v, 8'h02);
    wr(16'h0300, 0);
    rdsr(v); chk("R8 empty no busy", v, 8'h02);
    wait_done();
    peek(0, 10'h300, v); chk("R8 array kept", v, 8'hFF);

    op(8'h04); wrsr(8'h04);
    rdsr(v); chk("R9 needs wel", v, 8'h00);
    op(8'h06); wrsr(8'h04);
    rdsr(v); chk("R9 prot loaded", v, 8'h04);

    op(8'h06);
    tx[3] = 8'h5E; wr(16'h03F0, 1);
    rdsr(v); chk("R12 protected rejected", v, 8'h06);
    tx[3] = 8'h6F; wr(16'h02F0, 1);
    wait_done();
    peek(0, 10'h3F0, v); chk("R12 protected kept", v, 8'hFF);
    peek(0, 10'h2F0, v); chk("R12 unprotected written", v, 8'h6F);

    op(8'h06); wrsr(8'h10);
    rdsr(v); chk("R9 idsel set", v, 8'h10);
    op(8'h06);
    tx[3] = 8'h5A; tx[4] = 8'h5B; wr(16'hAB05, 2);
    wait_done();
    peek(1, 10'h005, v); chk("R10 id byte0", v, 8'h5A);
    peek(1, 10'h006, v); chk("R10 id byte1", v, 8'h5B);
    peek(0, 10'h305, v); chk("R10 main untouched", v, 8'hFF);
    rdsr(v); chk("R10 idsel cleared", v, 8'h00);

    op(8'h06); wrsr(8'h1C); op(8'h06);
    tx[3] = 8'hC1; wr(16'h0010, 1);
    rdsr(v); chk("R11 all protected no busy", v, 8'h1E);
    wait_done();
    peek(1, 10'h010, v); chk("R11 all protected kept", v, 8'hFF);

    op(8'h06); wrsr(8'h14); op(8'h06);
    tx[3] = 8'hC2; wr(16'h0310, 1);
    wait_done();
    peek(1, 10'h010, v); chk("R11 range rejected", v, 8'hFF);
    tx[3] = 8'hC3; wr(16'h0011, 1);
    wait_done();
    peek(1, 10'h011, v); chk("R11 outside range accepted", v, 8'hC3);
    rdsr(v); chk("R10 status after id write", v, 8'h04);

    op(8'h06); wrsr(8'h30); op(8'h06);
    tx[3] = 8'hC4; wr(16'h0020, 1);
    wait_done();
    peek(1, 10'h020, v); chk("R11 lock rejects", v, 8'hFF);
    peek(0, 10'h020, v); chk("R11 lock main kept", v, 8'hFF);
    op(8'h06); wrsr(8'h00);
    rdsr(v); chk("R9 lock sticky", v, 8'h20);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(8ns * 190000);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule